// File: doc/BRIEF.md
# NAND Page Reed-Solomon Parity Engine

This block computes six 10-bit Reed-Solomon check symbols over GF(2^10) for a 512-byte NAND page and can test a page against the check symbols stored next to it. Page bytes arrive one per clock on a valid/data stream. Each byte is bitwise inverted, widened to a 10-bit symbol with zero upper bits, and divided by the degree-6 generator polynomial in a six-stage LFSR. Because of the inversion, and because the parity is complemented on readout, an erased page of all 0xFF gives all-0xFF parity.

A 3-bit control write selects the operation. In generate mode the engine absorbs 512 bytes, and the parity can then be read as eight bytes. In check mode it also absorbs the eight stored parity bytes, in the form they were read out. It then raises an error flag if the combined remainder is nonzero, and it exposes the remainder bytes so that software can locate and fix errors. Correction itself is done elsewhere.

Top module: `nand_rs_ecc`

## Requirements
- R1: After reset, or after a control write with bit 0 (clear) set, parity addresses 0..7 read 0xFF, remainder addresses 8..15 read 0x00, err_o is low, and the byte count restarts at zero.
- R2: Control bit 1 selects generate and bit 2 enables data intake. A byte is absorbed only while the registered enable bit is set and in_valid_i is high. A control write of 0 holds all state, with no clearing, and the stream is then ignored.
- R3: A full page of 0xFF in generate mode reads back as eight 0xFF parity bytes.
- R4: The parity symbols equal the remainder of M(x)·x^6 divided by g(x) = ∏(x+α^i), i=0..5, over GF(2^10) with field polynomial x^10+x^3+1. M(x) has the inverted bytes as coefficients, with the first byte at the highest power. P5 is the x^5 coefficient.
- R5: The parity read at addresses 0..7 is the complement of a 64-bit word. In that word, P5 sits at bits 9:0, P4 at 19:10, P3 at 29:20, P2 at 39:30, P1 at 49:40, P0 at 59:50, and bits 63:60 are zero, so those bits read as 1. Address k returns word bits 8k+7:8k.
- R6: In generate mode done_o is high for exactly one cycle, the cycle after the edge that absorbs byte 512. Later bytes are ignored until the next clear.
- R7: In check mode (bits 2 set, bit 1 clear) bytes 513..520 are taken as the stored parity bytes for addresses 0..7. done_o pulses one cycle after byte 520.
- R8: After a check-mode done, err_o is high exactly when the remainder is nonzero. A single corrupted data byte or parity byte sets it. err_o holds until a clear.
- R9: Addresses 8..15 return remainder bytes. The remainder is the computed symbols XOR the uncomplemented stored symbols, packed as in R5 with the spare bits zero. Each byte is bit-reversed, so bit 0 of address 8+k is word bit 8k+7.
- R10: When a clear write and a valid byte fall in the same cycle, the clear wins and the byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 3 | Control value: bit0 clear, bit1 generate, bit2 data enable |
| in_valid_i | input | 1 | Page byte valid |
| in_data_i | input | 8 | Page or stored-parity byte |
| rd_addr_i | input | 4 | Read address: 0..7 parity, 8..15 remainder |
| rd_data_o | output | 8 | Combinational read data |
| err_o | output | 1 | Nonzero remainder after a completed check |
| done_o | output | 1 | One-cycle end-of-stream pulse |

## Verification
A clear write and a valid stream byte can land on the same edge. The bench provokes this in the middle of a page, while intake is enabled, and then sends a full fresh page. If the stray byte had been absorbed, done_o would arrive one cycle early and the parity would differ, so the model catches it in both the per-cycle done comparison and the readout. A control write can also share an edge with a byte under the old mode, and the model accepts that byte under the mode registered before the write.

// File: rtl/nand_rs_pkg.sv
`timescale 1ns/1ps
package nand_rs_pkg;
  localparam int SYM_W      = 10;
  localparam int NPAR       = 6;
  localparam int BYTE_W     = 8;
  localparam int PAGE_BYTES = 512;
  localparam int PAR_BYTES  = (NPAR * SYM_W + BYTE_W - 1) / BYTE_W;
  localparam int PAR_IW     = $clog2(PAR_BYTES);
  localparam int ADDR_W     = PAR_IW + 1;
  localparam int FLAT_W     = PAR_BYTES * BYTE_W;
  localparam int CTL_W      = 3;
  localparam int CTL_CLR    = 0;
  localparam int CTL_GEN    = 1;
  localparam int CTL_EN     = 2;
  localparam logic [SYM_W:0] FIELD_POLY = 11'h409;
  localparam logic [FLAT_W-1:0] SYM_MASK = {FLAT_W{1'b1}} >> (FLAT_W - NPAR * SYM_W);

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [NPAR-1:0][SYM_W-1:0] par_t;

  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc ^= sh;
      if (sh[SYM_W-1]) sh = {sh[SYM_W-2:0], 1'b0} ^ FIELD_POLY[SYM_W-1:0];
      else             sh = {sh[SYM_W-2:0], 1'b0};
    end
    return acc;
  endfunction

  // low NPAR coefficients of prod(x + alpha^i), i = 0..NPAR-1
  function automatic par_t gen_poly();
    sym_t c [NPAR+1];
    sym_t root;
    par_t g;
    for (int j = 0; j <= NPAR; j++) c[j] = '0;
    c[0] = sym_t'(1);
    root = sym_t'(1);
    for (int i = 0; i < NPAR; i++) begin
      for (int j = NPAR; j > 0; j--) c[j] = c[j-1] ^ gf_mul(c[j], root);
      c[0] = gf_mul(c[0], root);
      root = gf_mul(root, sym_t'(2));
    end
    for (int j = 0; j < NPAR; j++) g[j] = c[j];
    return g;
  endfunction

  // highest-order symbol lands in the lowest bits
  function automatic logic [FLAT_W-1:0] pack_par(par_t p);
    logic [FLAT_W-1:0] f;
    f = '0;
    for (int k = 0; k < NPAR; k++) f[k*SYM_W +: SYM_W] = p[NPAR-1-k];
    return f;
  endfunction
endpackage

// File: rtl/nand_rs_lfsr.sv
`timescale 1ns/1ps
module nand_rs_lfsr
  import nand_rs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  input  sym_t sym_i,
  output par_t state_o
);
  localparam par_t GEN = gen_poly();

  par_t state_q, state_d;
  sym_t fb;
  sym_t prod [NPAR];

  assign fb = sym_i ^ state_q[NPAR-1];

  for (genvar k = 0; k < NPAR; k++) begin : g_tap
    assign prod[k] = gf_mul(fb, GEN[k]);
  end

  always_comb begin
    state_d = state_q;
    if (clear_i) begin
      state_d = '0;
    end else if (step_i) begin
      state_d[0] = prod[0];
      for (int k = 1; k < NPAR; k++) state_d[k] = state_q[k-1] ^ prod[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  a_r1_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> state_q == '0);
  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i && !step_i |=> $stable(state_q));
endmodule

// File: rtl/nand_rs_seq.sv
`timescale 1ns/1ps
module nand_rs_seq
  import nand_rs_pkg::*;
#(
  parameter int PAGE   = PAGE_BYTES,
  parameter int NSTORE = PAR_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTL_W-1:0]  ctrl_i,
  input  logic              valid_i,
  output logic              clear_o,
  output logic              step_o,
  output logic              cap_o,
  output logic [PAR_IW-1:0] cap_idx_o,
  output logic              done_o,
  output logic              chk_full_o
);
  localparam int TOTAL = PAGE + NSTORE;
  localparam int CW    = $clog2(TOTAL + 1);

  logic          en_q, gen_q, done_q, full_q;
  logic [CW-1:0] cnt_q, lim;
  logic          accept, last;

  assign clear_o   = ctrl_we_i & ctrl_i[CTL_CLR];
  assign lim       = gen_q ? CW'(PAGE) : CW'(TOTAL);
  assign accept    = !clear_o && en_q && valid_i && (cnt_q < lim);
  assign last      = accept && (cnt_q == lim - CW'(1));
  assign step_o    = accept && (cnt_q < CW'(PAGE));
  assign cap_o     = accept && !step_o;
  assign cap_idx_o = PAR_IW'(cnt_q - CW'(PAGE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      gen_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (ctrl_we_i) begin
        en_q  <= ctrl_i[CTL_EN];
        gen_q <= ctrl_i[CTL_GEN];
      end
      if (clear_o) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
        full_q <= 1'b0;
      end else begin
        if (accept) cnt_q <= cnt_q + CW'(1);
        done_q <= last;
        if (last && !gen_q) full_q <= 1'b1;
      end
    end
  end

  assign done_o     = done_q;
  assign chk_full_o = full_q;

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(TOTAL));
  a_r10_clear_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> cnt_q == '0 && !done_o && !chk_full_o);
  a_r7_full_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chk_full_o) |-> done_o);
endmodule

// File: rtl/nand_rs_readout.sv
`timescale 1ns/1ps
module nand_rs_readout
  import nand_rs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              cap_i,
  input  logic [PAR_IW-1:0] cap_idx_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  par_t              state_i,
  input  logic              chk_full_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              err_o
);
  logic [PAR_BYTES-1:0][BYTE_W-1:0] stored_q;
  logic [PAR_BYTES-1:0][BYTE_W-1:0] par_bytes, rem_rev;
  logic [FLAT_W-1:0]                par_flat, rem_flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stored_q <= '1;
    else if (clear_i) stored_q <= '1;
    else if (cap_i)   stored_q[cap_idx_i] <= byte_i;
  end

  assign par_flat = pack_par(state_i);
  // stored bytes come in readout (complemented) form
  assign rem_flat = par_flat ^ (~stored_q & SYM_MASK);

  for (genvar i = 0; i < PAR_BYTES; i++) begin : g_byte
    assign par_bytes[i] = ~par_flat[i*BYTE_W +: BYTE_W];
    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
      assign rem_rev[i][b] = rem_flat[i*BYTE_W + BYTE_W - 1 - b];
    end
  end

  assign rd_data_o = rd_addr_i[PAR_IW] ? rem_rev[rd_addr_i[PAR_IW-1:0]]
                                       : par_bytes[rd_addr_i[PAR_IW-1:0]];
  assign err_o = chk_full_i & (|rem_flat);

  a_r9_clear_rem_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> rem_flat == '0);
endmodule

// File: rtl/nand_rs_ecc.sv
`timescale 1ns/1ps
module nand_rs_ecc
  import nand_rs_pkg::*;
#(
  parameter int PAGE_LEN = PAGE_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTL_W-1:0]  ctrl_wdata_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              err_o,
  output logic              done_o
);
  logic              clear, step, cap, chk_full;
  logic [PAR_IW-1:0] cap_idx;
  sym_t              sym;
  par_t              state;

  assign sym = {{(SYM_W-BYTE_W){1'b0}}, ~in_data_i};

  nand_rs_seq #(.PAGE(PAGE_LEN), .NSTORE(PAR_BYTES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (ctrl_we_i),
    .ctrl_i     (ctrl_wdata_i),
    .valid_i    (in_valid_i),
    .clear_o    (clear),
    .step_o     (step),
    .cap_o      (cap),
    .cap_idx_o  (cap_idx),
    .done_o     (done_o),
    .chk_full_o (chk_full)
  );

  nand_rs_lfsr u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .step_i  (step),
    .sym_i   (sym),
    .state_o (state)
  );

  nand_rs_readout u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .cap_i      (cap),
    .cap_idx_i  (cap_idx),
    .byte_i     (in_data_i),
    .state_i    (state),
    .chk_full_i (chk_full),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .err_o      (err_o)
  );

  a_r8_err_in_check: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
endmodule

// File: tb/sim_nand_rs_ecc.sv
`timescale 1ns/1ps
module sim_nand_rs_ecc;
  logic       clk = 1'b0, rst_n = 1'b0, we = 1'b0, v = 1'b0;
  logic [2:0] wd = '0;
  logic [7:0] d = '0;
  logic [3:0] ra = '0;
  logic [7:0] rdat;
  logic       err, done;

  nand_rs_ecc u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(we), .ctrl_wdata_i(wd),
    .in_valid_i(v), .in_data_i(d), .rd_addr_i(ra), .rd_data_o(rdat),
    .err_o(err), .done_o(done)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  int exp_t [0:1022];
  int log_t [0:1023];
  int gc [0:6];

  bit m_en = 0, m_gen = 0, m_done = 0, m_full = 0;
  int m_cnt = 0;
  logic [7:0] pg [0:519];
  logic [7:0] st [0:7];
  logic [7:0] orig [0:511];
  logic [7:0] sv [0:7];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  function automatic int gmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return exp_t[(log_t[a] + log_t[b]) % 1023];
  endfunction

  task automatic init_field();
    int x = 1;
    for (int i = 0; i < 1023; i++) begin
      exp_t[i] = x;
      log_t[x] = i;
      x = x << 1;
      if (x & 'h400) x = x ^ 'h409;
    end
    for (int j = 0; j < 7; j++) gc[j] = 0;
    gc[0] = 1;
    for (int i = 0; i < 6; i++) begin
      for (int j = 6; j > 0; j--) gc[j] = gc[j-1] ^ gmul(gc[j], exp_t[i]);
      gc[0] = gmul(gc[0], exp_t[i]);
    end
  endtask

  // long division of the inverted page times x^6 by g(x)
  function automatic logic [63:0] model_par();
    int r [0:517];
    int n;
    logic [63:0] f;
    n = (m_cnt < 512) ? m_cnt : 512;
    f = '0;
    for (int k = 0; k < 518; k++) r[k] = 0;
    for (int k = 0; k < n; k++) r[k] = 255 - int'(pg[k]);
    for (int k = 0; k < n; k++) begin
      int c = r[k];
      for (int j = 1; j <= 6; j++) r[k+j] = r[k+j] ^ gmul(c, gc[6-j]);
    end
    for (int j = 0; j < 6; j++) f[j*10 +: 10] = 10'(r[n+j]);
    return f;
  endfunction

  function automatic logic [63:0] model_rem();
    logic [63:0] s;
    for (int i = 0; i < 8; i++) s[i*8 +: 8] = st[i];
    return model_par() ^ (~s & 64'h0FFF_FFFF_FFFF_FFFF);
  endfunction

  task automatic cyc(bit w, logic [2:0] c, bit vv, logic [7:0] dd);
    int lim;
    bit acc, clr;
    @(negedge clk);
    chk(done == m_done, m_gen ? "R6 done" : "R7 done", 64'(done), 64'(m_done));
    we = w; wd = c; v = vv; d = dd;
    clr = w && c[0];
    lim = m_gen ? 512 : 520;
    acc = !clr && m_en && vv && (m_cnt < lim);
    m_done = 0;
    if (clr) begin
      m_cnt = 0; m_full = 0;
      for (int i = 0; i < 8; i++) st[i] = 8'hFF;
    end else if (acc) begin
      pg[m_cnt] = dd;
      if (m_cnt >= 512) st[m_cnt-512] = dd;
      m_cnt++;
      if (m_cnt == lim) begin
        m_done = 1;
        if (!m_gen) m_full = 1;
      end
    end
    if (w) begin m_en = c[2]; m_gen = c[1]; end
  endtask

  task automatic read_all(string req);
    logic [63:0] p, r;
    logic [7:0] e;
    p = model_par();
    r = model_rem();
    chk(err == (m_full && r != 0), {req, " R8 err"}, 64'(err), 64'(m_full && r != 0));
    for (int a = 0; a < 16; a++) begin
      ra = 4'(a);
      #0.4;
      if (a < 8) begin
        e = ~p[a*8 +: 8];
        chk(rdat == e, {req, " R5 parity"}, 64'(rdat), 64'(e));
      end else begin
        for (int b = 0; b < 8; b++) e[b] = r[(a-8)*8 + 7 - b];
        chk(rdat == e, {req, " R9 remainder"}, 64'(rdat), 64'(e));
      end
    end
  endtask

  task automatic run_check(int bad_sym, logic [7:0] dmask, int bad_par, logic [7:0] pmask);
    cyc(1, 3'b101, 0, 0);
    for (int i = 0; i < 512; i++) cyc(0, 0, 1, orig[i] ^ ((i == bad_sym) ? dmask : 8'h00));
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, sv[i] ^ ((i == bad_par) ? pmask : 8'h00));
    cyc(0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] f;
    init_field();
    for (int i = 0; i < 8; i++) st[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(done == 0, "R1 reset done", 64'(done), 0);
    read_all("R1 reset");

    // R3: erased page
    cyc(1, 3'b111, 0, 0);
    for (int i = 0; i < 512; i++) cyc(0, 0, 1, 8'hFF);
    cyc(0, 0, 0, 0);
    read_all("R3");
    for (int a = 0; a < 8; a++) begin
      ra = 4'(a); #0.4;
      chk(rdat == 8'hFF, "R3 erased parity", 64'(rdat), 64'hFF);
    end

    // R4/R6: random page with gaps, then extra bytes that must be ignored
    cyc(1, 3'b111, 0, 0);
    for (int i = 0; i < 512; i++) begin
      if (i % 37 == 5) cyc(0, 0, 0, 0);
      cyc(0, 0, 1, 8'($urandom));
    end
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 8'($urandom));
    cyc(0, 0, 0, 0);
    read_all("R4 R6");
    f = model_par();
    for (int i = 0; i < 512; i++) orig[i] = pg[i];
    for (int i = 0; i < 8; i++) sv[i] = ~f[i*8 +: 8];

    // R7/R8: clean check
    run_check(-1, 8'h00, -1, 8'h00);
    chk(err == 0, "R8 clean page err", 64'(err), 0);
    read_all("R7 clean");

    // R8/R9: one data symbol corrupted
    run_check(37, 8'h5A, -1, 8'h00);
    chk(err == 1, "R8 data corruption err", 64'(err), 1);
    read_all("R9 data corruption");

    // R8: one stored parity byte corrupted
    run_check(-1, 8'h00, 3, 8'h10);
    chk(err == 1, "R8 parity corruption err", 64'(err), 1);
    read_all("R8 parity corruption");

    // R2: write of 0 holds everything, stream ignored
    cyc(1, 3'b000, 0, 0);
    for (int i = 0; i < 20; i++) cyc(0, 0, 1, 8'($urandom));
    cyc(0, 0, 0, 0);
    chk(err == 1, "R2 hold err", 64'(err), 1);
    read_all("R2 hold");

    // R10: clear collides with a valid byte mid-page
    cyc(1, 3'b111, 0, 0);
    for (int i = 0; i < 100; i++) cyc(0, 0, 1, 8'($urandom));
    cyc(1, 3'b111, 1, 8'h3C);
    for (int i = 0; i < 512; i++) cyc(0, 0, 1, 8'($urandom));
    cyc(0, 0, 0, 0);
    read_all("R10 collision");

    // R1: clear afterwards
    cyc(1, 3'b111, 0, 0);
    cyc(0, 0, 0, 0);
    read_all("R1 clear");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule